// File: doc/BRIEF.md
# Phase Compensation Bit FIFO

This block carries a single recovered serial bit from the clock chosen by a phase selector into the receiver's local clock. Both clocks run at the same frequency, but their relative phase is unknown and fixed, so a six-entry circular buffer of one-bit cells absorbs the static offset. The writer fills one cell per write-clock edge. The reader empties one cell per read-clock edge. After every reinitialisation the reader trails the writer by half the buffer, which leaves three bits of slack in each direction.

Three sources can restart the pointers: an active-low external reset, a one-cycle pulse from the phase selector when it first locks, and a flush input that the surrounding logic raises after it detects corrupted data. All three are merged into one request, asserted asynchronously, and released through a two-stage synchroniser in each clock domain. The write pointer is Johnson coded, so it changes one bit per step. It is synchronised into the read domain, where an estimate of the pointer separation drives a sticky error flag. A bypass input sends the incoming bit straight to the output when phase alignment is not in use.

Top module: `phase_bit_fifo`

## Requirements
- R1: Outside reset and with both clocks running, the output (bypass low) equals the input delayed by a fixed number of cycles, and that number does not change until the next reinitialisation.
- R2: While reset is applied, the output bit and the error flag are 0. When reset releases, the write index starts at entry 0 and the read index at entry 3. The bench measures this as a latency of 2 to 6 cycles between the write count and the read sample.
- R3: A low level on the external reset reinitialises both pointers, clears the error flag and drives the output to 0, asynchronously to either clock.
- R4: A single read-clock-cycle pulse on the lock input reinitialises both pointers and clears the error flag, after which R1 holds again.
- R5: A single-cycle pulse on the flush input reinitialises both pointers and clears the error flag, after which R1 holds again.
- R6: With bypass high, the output equals the input bit combinationally, whatever state the buffer and the resets are in.
- R7: The error flag stays 0 in steady operation. It goes to 1 once the estimated pointer separation (synchronised write index plus the synchroniser depth, minus the read index, modulo 6) reaches 0. It stays at 1 until one of the three reinitialisation sources acts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write clock, the phase chosen by the phase selector |
| rclk_i | input | 1 | Read clock, the local receiver clock at the same frequency |
| rst_ni | input | 1 | External reset, active low, asynchronous assertion |
| lock_i | input | 1 | Pulse marking the first lock of the phase selector |
| flush_i | input | 1 | Reinitialisation request from internal logic |
| bypass_i | input | 1 | 1 routes din_i straight to dout_o |
| din_i | input | 1 | Serial bit in the write-clock domain |
| dout_o | output | 1 | Serial bit in the read-clock domain, or din_i under bypass |
| err_o | output | 1 | Sticky flag, set when the pointer separation collapses (read domain) |

## Verification
Bypass and a reinitialisation can happen in the same cycle. The bench raises bypass and then pulses flush while bypass is still high. It checks on every read cycle that the output keeps following the input while the pointers restart underneath. After bypass drops, it learns the latency again and checks it against R1 and R2. A second overlap is a lock pulse that arrives while the sticky error is set. The bench makes the pointers drift by stopping the write clock for four periods, and then requires that the lock pulse clears the flag.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

    localparam int unsigned PF_DEPTH = 6;
    localparam int unsigned PF_GAP   = 3;
    localparam int unsigned PF_SYNC  = 2;

    // Position of a Johnson-coded pointer of width jw (cycle length 2*jw).
    function automatic int unsigned pf_jc_index(logic [31:0] jc, int unsigned jw);
        int unsigned ones;
        ones = 0;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i < jw && jc[i]) ones++;
        end
        return jc[jw-1] ? (2 * jw - ones) : ones;
    endfunction

    function automatic int unsigned pf_wrap(int unsigned v, int unsigned m);
        return v % m;
    endfunction

endpackage

// File: rtl/pfifo_rst_sync.sv
module pfifo_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic req_i,
    output logic rst_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], 1'b0};
    end

    always_ff @(posedge clk_i or posedge req_i) begin
        if (req_i) sh_q <= '1;
        else       sh_q <= sh_d;
    end

    assign rst_o = sh_q[STAGES-1];
endmodule

// File: rtl/pfifo_wr.sv
module pfifo_wr
    import pfifo_pkg::*;
#(
    parameter int unsigned DEPTH = PF_DEPTH,
    localparam int unsigned JW   = DEPTH / 2,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             din_i,
    output logic [JW-1:0]    jc_o,
    output logic [DEPTH-1:0] mem_o
);
    typedef struct packed {
        logic [JW-1:0]    jc;
        logic [DEPTH-1:0] mem;
    } wr_state_t;

    localparam wr_state_t WR_RST = '{jc: '0, mem: '0};

    wr_state_t       st_d, st_q;
    logic [AW-1:0]   widx;

    always_comb begin
        st_d            = st_q;
        widx            = AW'(pf_jc_index(32'(st_q.jc), JW));
        st_d.mem[widx]  = din_i;
        st_d.jc         = {st_q.jc[JW-2:0], ~st_q.jc[JW-1]};
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= WR_RST;
        else       st_q <= st_d;
    end

    assign jc_o  = st_q.jc;
    assign mem_o = st_q.mem;
endmodule

// File: rtl/pfifo_rd.sv
module pfifo_rd
    import pfifo_pkg::*;
#(
    parameter int unsigned DEPTH  = PF_DEPTH,
    parameter int unsigned GAP    = PF_GAP,
    parameter int unsigned STAGES = PF_SYNC,
    localparam int unsigned JW    = DEPTH / 2,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [JW-1:0]    wjc_i,
    input  logic [DEPTH-1:0] mem_i,
    output logic             bit_o,
    output logic [AW-1:0]    ridx_o,
    output logic             err_o
);
    localparam logic [AW-1:0] RD_INIT = AW'((DEPTH - GAP) % DEPTH);

    typedef struct packed {
        logic [AW-1:0]               ridx;
        logic                        dq;
        logic [STAGES-1:0][JW-1:0]   wsync;
        logic                        err;
    } rd_state_t;

    localparam rd_state_t RD_RST = '{ridx: RD_INIT, dq: 1'b0, wsync: '0, err: 1'b0};

    rd_state_t   st_d, st_q;
    int unsigned sep;

    always_comb begin
        st_d       = st_q;
        st_d.dq    = mem_i[st_q.ridx];
        st_d.ridx  = (st_q.ridx == AW'(DEPTH - 1)) ? '0 : st_q.ridx + 1'b1;
        st_d.wsync = {st_q.wsync[STAGES-2:0], wjc_i};
        sep        = pf_wrap(pf_jc_index(32'(st_q.wsync[STAGES-1]), JW) + STAGES
                             + DEPTH - 32'(st_q.ridx), DEPTH);
        if (sep == 0) st_d.err = 1'b1;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= RD_RST;
        else       st_q <= st_d;
    end

    assign bit_o  = st_q.dq;
    assign ridx_o = st_q.ridx;
    assign err_o  = st_q.err;
endmodule

// File: rtl/phase_bit_fifo.sv
module phase_bit_fifo
    import pfifo_pkg::*;
#(
    parameter int unsigned DEPTH  = PF_DEPTH,
    parameter int unsigned GAP    = PF_GAP,
    parameter int unsigned STAGES = PF_SYNC
) (
    input  logic wclk_i,
    input  logic rclk_i,
    input  logic rst_ni,
    input  logic lock_i,
    input  logic flush_i,
    input  logic bypass_i,
    input  logic din_i,
    output logic dout_o,
    output logic err_o
);
    localparam int unsigned JW = DEPTH / 2;
    localparam int unsigned AW = $clog2(DEPTH);

    logic             rst_req;
    logic             wr_rst, rd_rst;
    logic [JW-1:0]    wr_jc;
    logic [DEPTH-1:0] cells;
    logic             rd_bit;
    logic [AW-1:0]    rd_idx;

    assign rst_req = ~rst_ni | lock_i | flush_i;

    pfifo_rst_sync #(.STAGES(STAGES)) u_wsync (
        .clk_i (wclk_i), .req_i (rst_req), .rst_o (wr_rst)
    );

    pfifo_rst_sync #(.STAGES(STAGES)) u_rsync (
        .clk_i (rclk_i), .req_i (rst_req), .rst_o (rd_rst)
    );

    pfifo_wr #(.DEPTH(DEPTH)) u_wr (
        .clk_i (wclk_i), .rst_i (wr_rst), .din_i (din_i),
        .jc_o  (wr_jc),  .mem_o (cells)
    );

    pfifo_rd #(.DEPTH(DEPTH), .GAP(GAP), .STAGES(STAGES)) u_rd (
        .clk_i  (rclk_i), .rst_i (rd_rst), .wjc_i (wr_jc), .mem_i (cells),
        .bit_o  (rd_bit), .ridx_o (rd_idx), .err_o (err_o)
    );

    assign dout_o = bypass_i ? din_i : rd_bit;
endmodule

// File: rtl/pfifo_chk.sv
module pfifo_chk #(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned GAP   = 3,
    localparam int unsigned JW   = DEPTH / 2,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input logic          wclk_i,
    input logic          rclk_i,
    input logic          rst_ni,
    input logic          wr_rst,
    input logic          rd_rst,
    input logic [JW-1:0] wr_jc,
    input logic [AW-1:0] rd_idx,
    input logic          bypass_i,
    input logic          din_i,
    input logic          dout_o,
    input logic          err_o
);
    localparam logic [AW-1:0] RD_INIT = AW'((DEPTH - GAP) % DEPTH);

    AST_READ_STEP: assert property (@(posedge rclk_i) disable iff (rd_rst)
        !rd_rst |=> rd_idx == (($past(rd_idx) == AW'(DEPTH - 1)) ? '0 : $past(rd_idx) + 1'b1)); // R1

    AST_WRITE_ONE_BIT: assert property (@(posedge wclk_i) disable iff (wr_rst)
        !wr_rst |=> $countones(wr_jc ^ $past(wr_jc)) == 1); // R1

    AST_RESET_GAP: assert property (@(posedge rclk_i) disable iff (!rst_ni)
        $fell(rd_rst) |-> rd_idx == RD_INIT); // R2

    AST_BYPASS_PASS: assert property (@(posedge rclk_i) disable iff (!rst_ni)
        bypass_i |-> dout_o == din_i); // R6

    AST_ERR_STICKY: assert property (@(posedge rclk_i) disable iff (rd_rst)
        err_o |=> err_o); // R7
endmodule

bind phase_bit_fifo pfifo_chk #(.DEPTH(DEPTH), .GAP(GAP)) u_chk (
    .wclk_i (wclk_i), .rclk_i (rclk_i), .rst_ni (rst_ni),
    .wr_rst (wr_rst), .rd_rst (rd_rst), .wr_jc (wr_jc), .rd_idx (rd_idx),
    .bypass_i (bypass_i), .din_i (din_i), .dout_o (dout_o), .err_o (err_o)
);

// File: tb/phase_bit_fifo_test.sv
module phase_bit_fifo_test;
    logic rclk = 1'b0, wclk = 1'b0;
    logic rst_n = 1'b0, lock = 1'b0, flush = 1'b0, bypass = 1'b0, din = 1'b0;
    logic dout, err;

    int   errors = 0, checks = 0;
    int   lat = 4;
    int   wn = 0;
    int   wstall = 0;
    bit   done = 1'b0;
    logic hist [0:8191];

    phase_bit_fifo uut (
        .wclk_i (wclk), .rclk_i (rclk), .rst_ni (rst_n), .lock_i (lock),
        .flush_i (flush), .bypass_i (bypass), .din_i (din),
        .dout_o (dout), .err_o (err)
    );

    always #2.5 rclk = ~rclk;               // 200 MHz read clock

    initial begin                            // same-frequency write clock, offset phase
        #1.7;
        forever begin
            if (wstall > 0) begin
                wstall = wstall - 1;
                #5;
            end else begin
                wclk = 1'b1; #2.5;
                wclk = 1'b0; #2.5;
            end
        end
    end

    always @(posedge wclk) begin             // model: log every bit the writer takes
        hist[wn & 8191] = din;
        wn = wn + 1;
    end

    always @(negedge wclk) din <= 1'($urandom % 2);

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic learn(input string req);
        logic sd [0:31];
        int   sw [0:31];
        repeat (12) @(negedge rclk);
        for (int i = 0; i < 32; i++) begin
            @(negedge rclk);
            sd[i] = dout;
            sw[i] = wn;
        end
        lat = -1;
        for (int l = 1; l <= 8; l++) begin
            bit all;
            all = 1'b1;
            for (int i = 0; i < 32; i++)
                if (sd[i] !== hist[(sw[i] - l) & 8191]) all = 1'b0;
            if (all && lat < 0) lat = l;
        end
        chk(lat >= 2 && lat <= 6, req, "latency after reinit", lat, 4);
        if (lat < 0) lat = 4;
    endtask

    task automatic follow(input int n, input string req);
        repeat (n) begin
            @(negedge rclk);
            chk(dout === hist[(wn - lat) & 8191], req, "delayed bit",
                int'(dout), int'(hist[(wn - lat) & 8191]));
            chk(err === 1'b0, "R7", "error in steady run", int'(err), 0);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #200us;
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        // R2: reset state
        repeat (4) @(negedge rclk);
        chk(dout === 1'b0, "R2", "dout in reset", int'(dout), 0);
        chk(err === 1'b0, "R2", "err in reset", int'(err), 0);
        rst_n = 1'b1;
        learn("R2");
        follow(200, "R1");

        // R7: drift by stalling the write clock, flag must stick
        @(negedge rclk); wstall = 4;
        repeat (14) @(negedge rclk);
        chk(err === 1'b1, "R7", "err after drift", int'(err), 1);
        repeat (10) @(negedge rclk);
        chk(err === 1'b1, "R7", "err sticky", int'(err), 1);

        // R4: lock pulse clears the flag and restarts
        lock = 1'b1; @(negedge rclk); lock = 1'b0;
        repeat (4) @(negedge rclk);
        chk(err === 1'b0, "R4", "err after lock", int'(err), 0);
        learn("R4");
        follow(150, "R4");

        // R3: external reset, with error set beforehand
        wstall = 5;
        repeat (14) @(negedge rclk);
        chk(err === 1'b1, "R7", "err after second drift", int'(err), 1);
        #1.1 rst_n = 1'b0;
        #0.5;
        chk(dout === 1'b0, "R3", "dout in async reset", int'(dout), 0);
        chk(err === 1'b0, "R3", "err in async reset", int'(err), 0);
        @(negedge rclk); @(negedge rclk); rst_n = 1'b1;
        learn("R3");
        follow(150, "R3");

        // R6 with R5: bypass, and flush while bypass is high
        bypass = 1'b1;
        repeat (20) begin
            @(negedge rclk);
            chk(dout === din, "R6", "bypass follows din", int'(dout), int'(din));
        end
        flush = 1'b1;
        repeat (3) begin
            @(negedge rclk);
            chk(dout === din, "R6", "bypass during flush", int'(dout), int'(din));
        end
        flush = 1'b0;
        repeat (20) begin
            @(negedge rclk);
            chk(dout === din, "R6", "bypass after flush", int'(dout), int'(din));
        end
        bypass = 1'b0;
        learn("R5");
        follow(150, "R5");

        // R5: flush pulse alone clears a set error
        wstall = 4;
        repeat (14) @(negedge rclk);
        chk(err === 1'b1, "R7", "err after third drift", int'(err), 1);
        flush = 1'b1; @(negedge rclk); flush = 1'b0;
        repeat (4) @(negedge rclk);
        chk(err === 1'b0, "R5", "err after flush", int'(err), 0);
        learn("R5");
        follow(100, "R1");

        summary();
    end
endmodule